// File: doc/BRIEF.md
# Five-select ALU with output shifter

This block is a purely combinational arithmetic-logic unit of parameterised width (4 bits by default). It takes two operands, a carry input and a 5-bit operation select. It returns a result and a carry-out. An arithmetic path and a bitwise logic path both work on the operands. One select bit picks which of the two results goes on. A final shift stage, steered by the two top select bits, then passes, doubles, halves or clears the chosen value.

Every arithmetic variant comes from one shared adder that computes A + X + carry-in. The second operand X is picked from B, the inverse of B, all-ones or zero. Unsigned and two's-complement operands go through the same path; only their reading differs. The result appears in the same cycle the inputs are applied. The block has no clock and no state.

Top module: `alu5_core`

## Requirements
- R1: `sel_i[2]` picks the source of the shift stage: 0 takes the arithmetic result, 1 takes the logic result. Select bit positions are `sel_i[0]`=S0 up to `sel_i[4]`=S4.
- R2: With S2=0, the arithmetic result is chosen by {S1,S0,cin}. The codes are: 000 → A, 001 → A+1, 010 → A+B, 011 → A+B+1, 100 → A+~B, 101 → A−B (A+~B+1), 110 → A−1, 111 → A. All results are modulo 2^W.
- R3: With S2=1, the logic result is chosen by {S1,S0}: 00 → A AND B, 01 → A OR B, 10 → A XOR B, 11 → NOT A. `cin_i` has no effect on it.
- R4: The shift stage is chosen by {S4,S3}: 00 passes the value, 01 shifts it left by one, 10 shifts it right by one, 11 gives zero.
- R5: Both shifts are logical. Left shift drops the MSB and fills bit 0 with 0. Right shift drops the LSB and fills bit W−1 with 0.
- R6: `cout_o` is the adder's carry out of bit W−1 when S2=0, and 0 when S2=1. The shift stage never changes it.
- R7: The adder's second operand is zero for {S1,S0}=00, B for 01, ~B for 10 and all-ones for 11, with `cin_i` added. Decrement therefore wraps 0 to all-ones with carry 0. Code 111 returns A with carry 1. Incrementing all-ones gives 0 with carry 1.
- R8: Outputs follow the inputs within the same cycle, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry input to the shared adder |
| sel_i | input | 5 | Operation select, bit 0 = S0 … bit 4 = S4 |
| y_o | output | W | Result after the shift stage |
| cout_o | output | 1 | Carry-out of the adder (0 for logic operations) |

## Verification
The adder's carry and the shift stage both act on a single operation. A shifted arithmetic result must carry the carry of the unshifted sum, while the shifted value drops or gains a bit. The bench sets up this overlap with directed vectors whose sums overflow under a right shift or a clear. It also runs an exhaustive sweep of all select codes, carry values and operand pairs at width 4. In each case it checks that `y_o` shows the shifted value and that `cout_o` still equals the carry of the raw sum.

// File: rtl/alu5_pkg.sv
// Package: shared encodings for the five-select ALU.
// Assumes: select bit order S0..S4 maps to sel_i[0]..sel_i[4].
package alu5_pkg;

    // Shift stage modes, encoded as {S4,S3}
    typedef enum logic [1:0] {
        SHF_PASS  = 2'b00,
        SHF_LEFT  = 2'b01,
        SHF_RIGHT = 2'b10,
        SHF_CLEAR = 2'b11
    } shf_mode_e;

    // Adder second-operand choice, encoded as {S1,S0}
    typedef enum logic [1:0] {
        ADDEND_ZERO = 2'b00,
        ADDEND_B    = 2'b01,
        ADDEND_NOTB = 2'b10,
        ADDEND_ONES = 2'b11
    } addend_e;

    // Logic unit operations, encoded as {S1,S0}
    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTA = 2'b11
    } lop_e;

    localparam int unsigned SEL_W   = 5;
    localparam int unsigned SEL_SRC = 2;   // S2: arithmetic/logic pick
    localparam int unsigned SEL_SHL = 3;   // low bit of shift mode

endpackage

// File: rtl/alu5_arith.sv
// Module: alu5_arith
// Arithmetic unit with a single shared adder. It computes A + X + cin, where X
// is picked from zero, B, ~B or all-ones by a 2-bit code.
// Assumes: purely combinational; the carry out is the adder's bit-W carry.
module alu5_arith #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [1:0]   op_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    import alu5_pkg::*;

    localparam int unsigned SW = W + 1;

    logic [W-1:0]  addend;
    logic [SW-1:0] wide_sum;

    // Pick the second adder operand from the op code
    always_comb begin
        unique case (addend_e'(op_i))
            ADDEND_ZERO: addend = '0;
            ADDEND_B:    addend = b_i;
            ADDEND_NOTB: addend = ~b_i;
            ADDEND_ONES: addend = '1;
            default:     addend = '0;
        endcase
    end

    // The one adder shared by every arithmetic variant
    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, addend} + SW'(cin_i);
    end

    assign sum_o  = wide_sum[W-1:0];
    assign cout_o = wide_sum[W];

    // Guard: zero addend without carry leaves A unchanged, no carry (R2)
    always_comb begin
        if (!$isunknown({a_i, op_i, cin_i}) && op_i == 2'b00 && !cin_i) begin
            p_zero_addend_passes_a_r2: assert (sum_o == a_i && !cout_o)
                else $error("p_zero_addend_passes_a_r2");
        end
    end

    // Guard: all-ones addend plus carry wraps back to A with carry set (R7)
    always_comb begin
        if (!$isunknown({a_i, op_i, cin_i}) && op_i == 2'b11 && cin_i) begin
            p_ones_wrap_r7: assert (sum_o == a_i && cout_o)
                else $error("p_ones_wrap_r7");
        end
    end

endmodule

// File: rtl/alu5_logic.sv
// Module: alu5_logic
// Bitwise logic unit: AND, OR, XOR of the operands, or the inverse of A.
// Assumes: no carry input; purely combinational.
module alu5_logic #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   op_i,
    output logic [W-1:0] res_o
);
    import alu5_pkg::*;

    // Select one bitwise function of the operands
    always_comb begin
        unique case (lop_e'(op_i))
            LOP_AND:  res_o = a_i & b_i;
            LOP_OR:   res_o = a_i | b_i;
            LOP_XOR:  res_o = a_i ^ b_i;
            LOP_NOTA: res_o = ~a_i;
            default:  res_o = '0;
        endcase
    end

    // Guard: the inverse of A shares no set bit with A and covers every bit (R3)
    always_comb begin
        if (!$isunknown({a_i, op_i}) && op_i == 2'b11) begin
            p_not_covers_r3: assert (((res_o & a_i) == '0) && ((res_o | a_i) == '1))
                else $error("p_not_covers_r3");
        end
    end

endmodule

// File: rtl/alu5_shift.sv
// Module: alu5_shift
// Output stage: pass, logical shift left by one, logical shift right by one,
// or clear, built one bit at a time.
// Assumes: W >= 2; vacated bits take zero.
module alu5_shift #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] val_i,
    input  logic [1:0]   mode_i,
    output logic [W-1:0] val_o
);
    import alu5_pkg::*;

    localparam int unsigned MSB = W - 1;

    logic [W-1:0] from_lower;   // neighbour feeding a left shift
    logic [W-1:0] from_upper;   // neighbour feeding a right shift

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign from_lower[i] = 1'b0;
        end else begin : g_lo
            assign from_lower[i] = val_i[i-1];
        end
        if (i == MSB) begin : g_msb
            assign from_upper[i] = 1'b0;
        end else begin : g_hi
            assign from_upper[i] = val_i[i+1];
        end

        // Per-bit mux between own value, neighbours and zero
        always_comb begin
            unique case (shf_mode_e'(mode_i))
                SHF_PASS:  val_o[i] = val_i[i];
                SHF_LEFT:  val_o[i] = from_lower[i];
                SHF_RIGHT: val_o[i] = from_upper[i];
                SHF_CLEAR: val_o[i] = 1'b0;
                default:   val_o[i] = 1'b0;
            endcase
        end
    end

    // Guard: a left shift empties bit 0 and never adds set bits (R5)
    always_comb begin
        if (!$isunknown({val_i, mode_i}) && mode_i == 2'b01) begin
            p_left_fill_r5: assert (!val_o[0] && ($countones(val_o) <= $countones(val_i)))
                else $error("p_left_fill_r5");
        end
    end

    // Guard: a right shift empties the MSB and never adds set bits (R5)
    always_comb begin
        if (!$isunknown({val_i, mode_i}) && mode_i == 2'b10) begin
            p_right_fill_r5: assert (!val_o[MSB] && ($countones(val_o) <= $countones(val_i)))
                else $error("p_right_fill_r5");
        end
    end

endmodule

// File: rtl/alu5_core.sv
// Module: alu5_core (top)
// Five-select combinational ALU. The shared-adder arithmetic unit and the
// logic unit feed a 2:1 pick on S2, followed by the shift stage on {S4,S3}.
// Assumes: no clock or state; carry-out comes only from the adder.
module alu5_core #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [4:0]   sel_i,
    output logic [W-1:0] y_o,
    output logic         cout_o
);
    import alu5_pkg::*;

    logic [W-1:0] arith_res;
    logic         arith_cy;
    logic [W-1:0] logic_res;
    logic [W-1:0] picked;
    logic         use_logic;

    assign use_logic = sel_i[SEL_SRC];

    alu5_arith #(.W(W)) u_arith (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .op_i   (sel_i[1:0]),
        .sum_o  (arith_res),
        .cout_o (arith_cy)
    );

    alu5_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (sel_i[1:0]),
        .res_o (logic_res)
    );

    // Choose the arithmetic or the logic result for the shift stage
    always_comb begin
        picked = use_logic ? logic_res : arith_res;
    end

    alu5_shift #(.W(W)) u_shift (
        .val_i  (picked),
        .mode_i (sel_i[SEL_SHL+1:SEL_SHL]),
        .val_o  (y_o)
    );

    // Carry-out comes from the adder only on arithmetic operations
    always_comb begin
        cout_o = use_logic ? 1'b0 : arith_cy;
    end

    // Guard: logic operations never raise carry-out (R6)
    always_comb begin
        if (!$isunknown(sel_i) && sel_i[SEL_SRC]) begin
            p_logic_no_carry_r6: assert (!cout_o)
                else $error("p_logic_no_carry_r6");
        end
    end

    // Guard: in pass mode the output equals the unit that S2 picked (R1)
    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i, sel_i}) && sel_i[4:3] == 2'b00) begin
            p_pass_follows_pick_r1: assert (y_o == (sel_i[SEL_SRC] ? logic_res : arith_res))
                else $error("p_pass_follows_pick_r1");
        end
    end

endmodule

// File: tb/alu5_core_bench.sv
// Bench for alu5_core at width 4: a directed vector table, reset and timing
// checks, then an exhaustive sweep against a model written from the requirements.
module alu5_core_bench;

    localparam int W = 4;
    localparam int NV = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b;
    logic         cin;
    logic [4:0]   sel;
    logic [W-1:0] y;
    logic         cout;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    alu5_core #(.W(W)) u_alu5_core (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sel_i  (sel),
        .y_o    (y),
        .cout_o (cout)
    );

    // Vector layout: {a[4], b[4], cin, sel[5], y[4], cout, tag[8]}
    localparam logic [26:0] VEC [NV] = '{
        {4'd5,  4'd3,  1'b0, 5'b00001, 4'd8,  1'b0, 8'd2},  // add
        {4'd9,  4'd9,  1'b1, 5'b00001, 4'd3,  1'b1, 8'd2},  // add with carry, overflow
        {4'd3,  4'd5,  1'b1, 5'b00010, 4'd14, 1'b0, 8'd2},  // subtract with borrow
        {4'd7,  4'd2,  1'b1, 5'b00010, 4'd5,  1'b1, 8'd2},  // subtract, no borrow
        {4'd4,  4'd4,  1'b0, 5'b00010, 4'd15, 1'b0, 8'd2},  // A + ~B
        {4'd10, 4'd3,  1'b0, 5'b00000, 4'd10, 1'b0, 8'd2},  // transfer A
        {4'd0,  4'd9,  1'b0, 5'b00011, 4'd15, 1'b0, 8'd7},  // decrement wraps
        {4'd15, 4'd0,  1'b1, 5'b00000, 4'd0,  1'b1, 8'd7},  // increment wraps
        {4'd6,  4'd1,  1'b1, 5'b00011, 4'd6,  1'b1, 8'd7},  // code 111 gives A
        {4'd12, 4'd10, 1'b1, 5'b00100, 4'd8,  1'b0, 8'd3},  // AND, cin ignored
        {4'd12, 4'd10, 1'b0, 5'b00110, 4'd6,  1'b0, 8'd3},  // XOR
        {4'd12, 4'd7,  1'b1, 5'b00111, 4'd3,  1'b0, 8'd3},  // NOT A
        {4'd5,  4'd6,  1'b0, 5'b01001, 4'd6,  1'b0, 8'd5},  // shl of sum, MSB dropped
        {4'd0,  4'd0,  1'b0, 5'b01111, 4'd14, 1'b0, 8'd5},  // shl of NOT, bit 0 zero
        {4'd9,  4'd9,  1'b0, 5'b10001, 4'd1,  1'b1, 8'd6},  // shr keeps adder carry
        {4'd15, 4'd15, 1'b1, 5'b11001, 4'd0,  1'b1, 8'd4},  // clear keeps adder carry
        {4'd5,  4'd2,  1'b0, 5'b10101, 4'd3,  1'b0, 8'd1}   // logic source shifted right
    };

    // Result expected from the requirement tables: {cout, y}
    function automatic logic [4:0] model(input logic [3:0] ma, input logic [3:0] mb,
                                         input logic mc, input logic [4:0] ms);
        logic [4:0] t;
        logic [3:0] v;
        if (!ms[2]) begin
            case (ms[1:0])
                2'b00:   t = {1'b0, ma} + 5'(mc);
                2'b01:   t = {1'b0, ma} + {1'b0, mb} + 5'(mc);
                2'b10:   t = {1'b0, ma} + {1'b0, ~mb} + 5'(mc);
                default: t = {1'b0, ma} + 5'd15 + 5'(mc);
            endcase
        end else begin
            case (ms[1:0])
                2'b00:   t = {1'b0, ma & mb};
                2'b01:   t = {1'b0, ma | mb};
                2'b10:   t = {1'b0, ma ^ mb};
                default: t = {1'b0, ~ma};
            endcase
        end
        case (ms[4:3])
            2'b00:   v = t[3:0];
            2'b01:   v = {t[2:0], 1'b0};
            2'b10:   v = {1'b0, t[3:1]};
            default: v = 4'd0;
        endcase
        return {t[4], v};
    endfunction

    task automatic check(input string tag, input logic [3:0] ey, input logic ec);
        n_cmp++;
        if (y !== ey || cout !== ec) begin
            n_bad++;
            $display("FAIL %s a=%0d b=%0d cin=%0b sel=%05b: y=%0d cout=%0b expected y=%0d cout=%0b",
                     tag, a, b, cin, sel, y, cout, ey, ec);
        end
    endtask

    task automatic drive(input logic [3:0] da, input logic [3:0] db,
                         input logic dc, input logic [4:0] ds);
        @(posedge clk);
        #1;
        a = da; b = db; cin = dc; sel = ds;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        a = '0; b = '0; cin = 1'b0; sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 reset state transfer of zero", 4'd0, 1'b0);
        rst_n = 1'b1;

        // R8: change inputs mid-cycle and see the result before any clock edge
        @(posedge clk);
        #1;
        a = 4'd6; b = 4'd7; cin = 1'b0; sel = 5'b00001;
        #0.5;
        check("R8 same-cycle response", 4'd13, 1'b0);

        // Directed vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][26:23], VEC[i][22:19], VEC[i][18], VEC[i][17:13]);
            check($sformatf("R%0d vector %0d", VEC[i][7:0], i), VEC[i][12:9], VEC[i][8]);
        end

        // R3: cin flip on OR must not move the result
        drive(4'd9, 4'd4, 1'b0, 5'b00101);
        check("R3 OR cin=0", 4'd13, 1'b0);
        drive(4'd9, 4'd4, 1'b1, 5'b00101);
        check("R3 OR cin=1 unchanged", 4'd13, 1'b0);

        // R6: overflowing arithmetic under every shift mode keeps the raw carry
        drive(4'd15, 4'd1, 1'b0, 5'b01001);
        check("R6 shl with carry", 4'd0, 1'b1);

        // Exhaustive sweep: R1 R2 R3 R4 R5 R6 R7 against the model
        for (int s = 0; s < 32; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int p = 0; p < 256; p++) begin
                    logic [4:0] exp;
                    string tg;
                    exp = model(4'(p >> 4), 4'(p), c[0], 5'(s));
                    tg = (s >= 8) ? "R4 sweep" : ((s & 4) != 0) ? "R3 sweep" : "R2 sweep";
                    drive(4'(p >> 4), 4'(p), c[0], 5'(s));
                    check(tg, exp[3:0], exp[4]);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule